// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Behaviour

This block is a synchronous RAM with two symmetric access ports, A and B. Each port has its own enable, byte-lane write enables, address, write data and read data. Any port can read or write any location. All inputs are captured on the rising clock edge. A read or a write completes on that one edge. Both ports run from a single clock, so a same-cycle clash between them has a defined outcome.

Each port has a compile-time write behaviour that sets what its read-data output shows after a cycle in which it writes. There are three choices. It can echo the freshly written word, show the word that was stored there before, or keep its previous output. The read-data output is a holding register: it changes only when its own port performs an enabled access. A parameter can add a pipeline register behind each output, which adds one cycle of read latency. A collision flag reports every cycle in which the two ports touch the same address and at least one of them writes. When both ports write the same address, port A's bytes take precedence.

Top module: `dpr_top`

## Requirements
- R1: An enabled access with all byte enables clear reads the word at its address. That word is on the port's read-data output after the next rising edge, or one edge later when the pipeline register is enabled.
- R2: An enabled write stores byte lane i (bits 8i+7..8i) only where write-enable bit i is set. The other lanes of the word keep their old contents.
- R3: In write-first behaviour, a write cycle loads the read-data output with the written word as this port forms it. That word is the write data on the enabled lanes and the old contents on the other lanes. This is the default behaviour.
- R4: In read-first behaviour, a write cycle loads the read-data output with the word stored at the address before the write.
- R5: In no-change behaviour, a write cycle leaves the read-data output unchanged.
- R6: While a port's enable is low, that port writes nothing and its read-data output holds its value, even if its write enables are set.
- R7: With the pipeline register enabled, each read-data value appears exactly one cycle later than it would without the register.
- R8: The collision flag is high in the cycle after an edge at which both ports were enabled at the same address and at least one of them had a write enable set. It is low after an edge at which both ports only read.
- R9: When both ports write the same address in one cycle, lanes enabled by port A take port A's data. Lanes enabled only by port B take port B's data.
- R10: While reset is low, both read-data outputs and the collision flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Asynchronous active-low reset of output and flag registers |
| aEn | input | 1 | Port A access enable |
| aWe | input | DATA_W/8 | Port A byte-lane write enables |
| aAddr | input | ADDR_W | Port A address |
| aWdata | input | DATA_W | Port A write data |
| aRdata | output | DATA_W | Port A read data |
| bEn | input | 1 | Port B access enable |
| bWe | input | DATA_W/8 | Port B byte-lane write enables |
| bAddr | input | ADDR_W | Port B address |
| bWdata | input | DATA_W | Port B write data |
| bRdata | output | DATA_W | Port B read data |
| collide | output | 1 | Same-address conflict seen at the previous edge |

## Verification
The hardest case to reach is the double write to one address with lane masks that only partly overlap. In that case the precedence rule, the collision flag and each port's write-behaviour output all act in the same cycle. The stimulus first fills a range of addresses from port A alone, so that every later old-contents value is known. It then drives both ports onto one address in the same cycle, with masks 0011 and 0110, and reads the word back. Two instances get the same stimulus: one with write-first and read-first ports and no pipeline, and one with no-change and write-first ports and the pipeline register. Together they cover all three behaviours with both latencies.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    WR_FIRST  = 2'd0,
    RD_FIRST  = 2'd1,
    NO_CHANGE = 2'd2
  } wmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic aWrite;   // port A stores enabled lanes
    logic aLoad;    // port A output register takes a new value
    logic aEcho;    // port A output takes the merged write word
    logic bWrite;
    logic bLoad;
    logic bEcho;
    logic bYield;   // port B drops lanes that port A also writes
  } dprStrobe_t;

endpackage

// File: rtl/dpr_ctrl.sv
module dpr_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter dpr_pkg::wmode_e MODE_A = dpr_pkg::WR_FIRST,
  parameter dpr_pkg::wmode_e MODE_B = dpr_pkg::WR_FIRST
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aEn,
  input  logic [LANES-1:0]  aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              bEn,
  input  logic [LANES-1:0]  bWe,
  input  logic [ADDR_W-1:0] bAddr,
  output dpr_pkg::dprStrobe_t strobe,
  output logic              collide
);
  import dpr_pkg::*;

  logic aWrAny, bWrAny, sameAddr, clash;

  always_comb begin
    aWrAny   = aEn && (|aWe);
    bWrAny   = bEn && (|bWe);
    sameAddr = aEn && bEn && (aAddr == bAddr);
    clash    = sameAddr && (aWrAny || bWrAny);

    strobe.aWrite = aWrAny;
    strobe.aLoad  = aEn && !(aWrAny && (MODE_A == NO_CHANGE));
    strobe.aEcho  = aWrAny && (MODE_A == WR_FIRST);
    strobe.bWrite = bWrAny;
    strobe.bLoad  = bEn && !(bWrAny && (MODE_B == NO_CHANGE));
    strobe.bEcho  = bWrAny && (MODE_B == WR_FIRST);
    strobe.bYield = sameAddr && aWrAny && bWrAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) collide <= 1'b0;
    else       collide <= clash;
  end

endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit OUT_REG = 1'b0,
  localparam int LANES  = DATA_W / 8,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpr_pkg::dprStrobe_t strobe,
  input  logic [LANES-1:0]  aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic [LANES-1:0]  bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic [DATA_W-1:0] bRdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] aOld, bOld, aMerged, bMerged;
  logic [DATA_W-1:0] aHold, bHold;
  logic [LANES-1:0]  aLane, bLane;

  always_comb begin
    aOld  = mem[aAddr];
    bOld  = mem[bAddr];
    aLane = strobe.aWrite ? aWe : '0;
    bLane = strobe.bWrite ? (bWe & ~(strobe.bYield ? aWe : '0)) : '0;
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign aMerged[i*8 +: 8] = aWe[i] ? aWdata[i*8 +: 8] : aOld[i*8 +: 8];
    assign bMerged[i*8 +: 8] = bWe[i] ? bWdata[i*8 +: 8] : bOld[i*8 +: 8];
  end

  // storage: port B lanes first, port A lanes last so A has precedence
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (bLane[i]) mem[bAddr][i*8 +: 8] <= bWdata[i*8 +: 8];
      if (aLane[i]) mem[aAddr][i*8 +: 8] <= aWdata[i*8 +: 8];
    end
  end

  // output holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aHold <= '0;
      bHold <= '0;
    end else begin
      if (strobe.aLoad) aHold <= strobe.aEcho ? aMerged : aOld;
      if (strobe.bLoad) bHold <= strobe.bEcho ? bMerged : bOld;
    end
  end

  if (OUT_REG) begin : gPipe
    logic [DATA_W-1:0] aPipe, bPipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aPipe <= '0;
        bPipe <= '0;
      end else begin
        aPipe <= aHold;
        bPipe <= bHold;
      end
    end
    assign aRdata = aPipe;
    assign bRdata = bPipe;
  end else begin : gDirect
    assign aRdata = aHold;
    assign bRdata = bHold;
  end

endmodule

// File: rtl/dpr_top.sv
module dpr_top #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter dpr_pkg::wmode_e MODE_A = dpr_pkg::WR_FIRST,
  parameter dpr_pkg::wmode_e MODE_B = dpr_pkg::WR_FIRST,
  parameter bit OUT_REG = 1'b0,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aEn,
  input  logic [LANES-1:0]  aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  input  logic              bEn,
  input  logic [LANES-1:0]  bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              collide
);

  dpr_pkg::dprStrobe_t strobe;

  dpr_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .aEn(aEn), .aWe(aWe), .aAddr(aAddr),
    .bEn(bEn), .bWe(bWe), .bAddr(bAddr),
    .strobe(strobe), .collide(collide)
  );

  dpr_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata),
    .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata),
    .aRdata(aRdata), .bRdata(bRdata)
  );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter dpr_pkg::wmode_e MODE_A = dpr_pkg::WR_FIRST,
  parameter bit OUT_REG = 1'b0,
  localparam int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              aEn,
  input logic [LANES-1:0]  aWe,
  input logic [ADDR_W-1:0] aAddr,
  input logic [DATA_W-1:0] aWdata,
  input logic [DATA_W-1:0] aRdata,
  input logic              bEn,
  input logic [LANES-1:0]  bWe,
  input logic [ADDR_W-1:0] bAddr,
  input logic              collide
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!aEn && $past(!aEn)) |=> $stable(aRdata)); // R6

  AST_READS_NO_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (aEn && bEn && aAddr == bAddr && aWe == '0 && bWe == '0) |=> !collide); // R8

  AST_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (aEn && bEn && aAddr == bAddr && (|aWe)) |=> collide); // R8

  if (!OUT_REG && MODE_A == dpr_pkg::WR_FIRST) begin : gEcho
    AST_ECHO_FULL_WORD: assert property (@(posedge clk) disable iff (!rstN)
      (aEn && aWe == '1) |=> (aRdata == $past(aWdata))); // R3
  end

  if (!OUT_REG && MODE_A == dpr_pkg::NO_CHANGE) begin : gKeep
    AST_KEEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (aEn && (|aWe)) |=> $stable(aRdata)); // R5
  end

endmodule

bind dpr_top dpr_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_A(MODE_A), .OUT_REG(OUT_REG)
) uChk (
  .clk(clk), .rstN(rstN),
  .aEn(aEn), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
  .bEn(bEn), .bWe(bWe), .bAddr(bAddr), .collide(collide)
);

// File: tb/tb_dpr_top.sv
module tb_dpr_top;
  import dpr_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        aEn = 0, bEn = 0;
  logic [3:0]  aWe = 0, bWe = 0;
  logic [7:0]  aAddr = 0, bAddr = 0;
  logic [31:0] aWdata = 0, bWdata = 0;
  logic [31:0] aRd1, bRd1, aRd2, bRd2;
  logic        col1, col2;

  // dut: write-first A, read-first B, no pipeline
  dpr_top #(.MODE_A(WR_FIRST), .MODE_B(RD_FIRST), .OUT_REG(1'b0)) dut (
    .clk(clk), .rstN(rstN),
    .aEn(aEn), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRd1),
    .bEn(bEn), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRd1),
    .collide(col1));

  // dutPipe: no-change A, write-first B, pipeline register on
  dpr_top #(.MODE_A(NO_CHANGE), .MODE_B(WR_FIRST), .OUT_REG(1'b1)) dutPipe (
    .clk(clk), .rstN(rstN),
    .aEn(aEn), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRd2),
    .bEn(bEn), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRd2),
    .collide(col2));

  typedef struct {
    int          due;
    int          id;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  logic [31:0] model [256];
  logic [31:0] lA1 = 0, lB1 = 0, lA2 = 0, lB2 = 0;

  function automatic logic [31:0] merge(logic [3:0] we, logic [31:0] old, logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = we[i] ? d[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] nextOut(wmode_e m, logic en, logic [3:0] we,
                                          logic [31:0] old, logic [31:0] d, logic [31:0] cur);
    if (!en) return cur;
    if (we == 4'b0) return old;
    case (m)
      WR_FIRST: return merge(we, old, d);
      RD_FIRST: return old;
      default:  return cur;
    endcase
  endfunction

  function automatic logic [31:0] pick(int id);
    case (id)
      0: return aRd1;
      1: return bRd1;
      2: return {31'b0, col1};
      3: return aRd2;
      default: return bRd2;
    endcase
  endfunction

  // monitor: compares queued expectations once they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = pick(it.id);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s output %0d: actual %h expected %h", it.tag, it.id, act, it.exp);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues expected outputs
  task automatic step(input logic ae, input logic [3:0] aw, input logic [7:0] aa, input logic [31:0] ad,
                      input logic be, input logic [3:0] bw, input logic [7:0] ba, input logic [31:0] bd,
                      input string tag);
    logic [31:0] oldA, oldB;
    logic expCol;
    item_t it;
    @(negedge clk);
    aEn = ae; aWe = aw; aAddr = aa; aWdata = ad;
    bEn = be; bWe = bw; bAddr = ba; bWdata = bd;
    oldA = model[aa];
    oldB = model[ba];
    expCol = ae && be && (aa == ba) && ((aw != 0) || (bw != 0));
    lA1 = nextOut(WR_FIRST,  ae, aw, oldA, ad, lA1);
    lB1 = nextOut(RD_FIRST,  be, bw, oldB, bd, lB1);
    lA2 = nextOut(NO_CHANGE, ae, aw, oldA, ad, lA2);
    lB2 = nextOut(WR_FIRST,  be, bw, oldB, bd, lB2);
    if (be) model[ba] = merge(bw & ~((ae && aa == ba) ? aw : 4'b0), model[ba], bd);
    if (ae) model[aa] = merge(aw, model[aa], ad);
    @(posedge clk);
    cyc++;
    it.due = cyc;     it.tag = tag;
    it.id = 0; it.exp = lA1; q.push_back(it);
    it.id = 1; it.exp = lB1; q.push_back(it);
    it.id = 2; it.exp = {31'b0, expCol}; it.tag = {tag, " R8"}; q.push_back(it);
    it.due = cyc + 1; it.tag = {tag, " R7"};
    it.id = 3; it.exp = lA2; q.push_back(it);
    it.id = 4; it.exp = lB2; q.push_back(it);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    checks++;
    if ({aRd1, bRd1, aRd2, bRd2, col1, col2} !== '0) begin
      errors++;
      $display("FAIL R10: actual %h %h %h %h %b %b expected all zero",
               aRd1, bRd1, aRd2, bRd2, col1, col2);
    end
    @(negedge clk);
    rstN = 1'b1;

    // preload through port A (write-first echo on dut) - R3
    for (int a = 0; a < 16; a++)
      step(1, 4'hF, 8'(a), 32'hA5A5_0000 ^ (32'(a) * 32'h1111_1111), 0, 4'h0, 8'h0, 32'h0, "R3");

    step(1, 4'h0, 8'd3, 32'h0, 1, 4'h0, 8'd7, 32'h0, "R1");
    step(1, 4'b0101, 8'd3, 32'hDEAD_BEEF, 0, 4'h0, 8'h0, 32'h0, "R2");
    step(1, 4'h0, 8'd3, 32'h0, 0, 4'h0, 8'h0, 32'h0, "R2");
    step(0, 4'h0, 8'h0, 32'h0, 1, 4'hF, 8'd7, 32'hCAFE_F00D, "R4");
    step(1, 4'hF, 8'd2, 32'h0BAD_C0DE, 0, 4'h0, 8'h0, 32'h0, "R5");
    step(0, 4'hF, 8'd2, 32'hFFFF_FFFF, 0, 4'hF, 8'd7, 32'h0, "R6");
    step(1, 4'h0, 8'd2, 32'h0, 1, 4'h0, 8'd7, 32'h0, "R6");
    step(1, 4'hF, 8'd4, 32'h1234_5678, 1, 4'h0, 8'd4, 32'h0, "R8");
    step(1, 4'h0, 8'd5, 32'h0, 1, 4'h0, 8'd5, 32'h0, "R8");
    step(1, 4'b0011, 8'd6, 32'h1111_2222, 1, 4'b0110, 8'd6, 32'h3333_4444, "R9");
    step(1, 4'h0, 8'd6, 32'h0, 0, 4'h0, 8'h0, 32'h0, "R9");
    step(0, 4'h0, 8'h0, 32'h0, 1, 4'h0, 8'd4, 32'h0, "R1");
    repeat (3) step(0, 4'h0, 8'h0, 32'h0, 0, 4'h0, 8'h0, 32'h0, "R6");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule